// File: doc/BRIEF.md
# Link Power State Request Controller

This block is the command word of one serial storage port. Software writes a 4-bit power command into the top of the word. The block then asks the serial link to move between three interface power states: active, partial and slumber. A request is taken only while the link layer reports idle and no earlier request is still open. The block tracks which power state the link is in. It clears the command field once the request has been handled, whether by the device, by a rule, or because the value was not valid.

A small request/response handshake stands in for the physical link. The block raises a request together with a target state and holds it until the device returns a one-cycle accept or reject pulse. When automatic power management is enabled, the block watches the command-issue and active-tag vectors. The moment both drain to empty, it requests a low-power state by itself. The same word also holds the configuration that gates an activity LED, and a write-once configuration nibble.

Top module: `link_pwr_cmd_ctrl`

## Requirements
- R1: After reset every bit of the read word is 0. The power state is active (0), and no link request is raised.
- R2: A write places bits 31:28 into the command field only if `link_idle_i` is 1 and no command or request is open. Otherwise the field keeps its value and no request follows.
- R3: Command 1 targets active, 2 targets partial and 6 targets slumber. The target is encoded on `lnk_tgt_o` and `pwr_state_o` as 0 = active, 1 = partial, 2 = slumber. The request is raised the cycle after the command is latched. It is held with a stable target until an accept or reject pulse arrives. On accept, the power state takes the target value.
- R4: When a request made from the command field completes, by accept or reject, the command field reads 0 from the next cycle.
- R5: On a reject pulse the power state stays unchanged.
- R6: A command for the current state, or a reserved value (3–5, 7–15), raises no request. It reads back for one cycle and then clears to 0.
- R7: From partial or slumber, a command for the other low-power state raises no request and clears like R6. Only active may be requested out of a low-power state.
- R8: If bit 26 is set, the state is active and nothing is open, then a cycle in which the OR of both vectors falls from non-zero to zero raises a request the next cycle. The request targets partial when bit 27 is 0 and slumber when it is 1.
- R9: `led_o` is 1 exactly when bits 24 and 25 are both 1 and any bit of the two vectors is set.
- R10: Bits 21:18 take the value of the first write after reset and ignore every later write.
- R11: The read word holds the command at 31:28, the configuration bits at 27:24, the write-once nibble at 21:18 and the power state at 17:16. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the command word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read word |
| link_idle_i | input | 1 | Link layer reports idle |
| cmd_issue_i | input | SLOTS | Command-issue vector |
| tag_active_i | input | SLOTS | Active-tag vector |
| lnk_req_o | output | 1 | Link power request open |
| lnk_tgt_o | output | 2 | Requested power state |
| lnk_ack_i | input | 1 | Device accepts (one-cycle pulse) |
| lnk_nak_i | input | 1 | Device rejects (one-cycle pulse) |
| pwr_state_o | output | 2 | Current interface power state |
| led_o | output | 1 | Activity LED |

## Verification
The assertions assume that the device responder pulses accept or reject only while a request is open, and never both in the same cycle. The stimulus has the responder pulse only after it has seen `lnk_req_o` high, and it drops the pulse as soon as the request falls. The assertions also assume that a drain of the command vectors does not coincide with a command write that is latched. The stimulus clears the vectors only while no register write is in flight.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_HI = 31;
  localparam int unsigned CMD_LO = 28;
  localparam int unsigned SEL_BIT = 27;
  localparam int unsigned AUTO_BIT = 26;
  localparam int unsigned LEDEN_BIT = 25;
  localparam int unsigned ATAPI_BIT = 24;
  localparam int unsigned ONCE_HI = 21;
  localparam int unsigned ONCE_LO = 18;
  localparam int unsigned PWR_HI = 17;
  localparam int unsigned PWR_LO = 16;
  localparam int unsigned CMD_W = CMD_HI - CMD_LO + 1;
  localparam int unsigned ONCE_W = ONCE_HI - ONCE_LO + 1;
  localparam int unsigned PWR_W = PWR_HI - PWR_LO + 1;

  localparam logic [PWR_W-1:0] PWR_ACTIVE  = 2'd0;
  localparam logic [PWR_W-1:0] PWR_PARTIAL = 2'd1;
  localparam logic [PWR_W-1:0] PWR_SLUMBER = 2'd2;

  localparam logic [CMD_W-1:0] CMD_NOP     = 4'h0;
  localparam logic [CMD_W-1:0] CMD_ACTIVE  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_PARTIAL = 4'h2;
  localparam logic [CMD_W-1:0] CMD_SLUMBER = 4'h6;

  typedef struct packed {
    logic                  valid;
    logic [PWR_W-1:0]      tgt;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_dec_t d;
    d.valid = 1'b1;
    d.tgt   = PWR_ACTIVE;
    case (c)
      CMD_ACTIVE:  d.tgt = PWR_ACTIVE;
      CMD_PARTIAL: d.tgt = PWR_PARTIAL;
      CMD_SLUMBER: d.tgt = PWR_SLUMBER;
      default:     d.valid = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lpc_cfg_regs.sv
module lpc_cfg_regs
  import lpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic [ONCE_W-1:0] once_wdata_i,
  output logic              sel_slumber_o,
  output logic              auto_en_o,
  output logic              led_en_o,
  output logic              atapi_o,
  output logic [ONCE_W-1:0] once_o
);
  logic [3:0]        cfg_q;
  logic [ONCE_W-1:0] once_q;
  logic              once_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      once_q      <= '0;
      once_done_q <= 1'b0;
    end else if (we_i) begin
      cfg_q <= cfg_wdata_i;
      if (!once_done_q) begin
        once_q      <= once_wdata_i;
        once_done_q <= 1'b1;
      end
    end
  end

  assign sel_slumber_o = cfg_q[3];
  assign auto_en_o     = cfg_q[2];
  assign led_en_o      = cfg_q[1];
  assign atapi_o       = cfg_q[0];
  assign once_o        = once_q;
endmodule

// File: rtl/lpc_drain_det.sv
module lpc_drain_det #(
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] cmd_issue_i,
  input  logic [SLOTS-1:0] tag_active_i,
  input  logic             led_en_i,
  input  logic             atapi_i,
  output logic             drain_o,
  output logic             led_o
);
  logic any_now;
  logic any_q;

  assign any_now = |(cmd_issue_i | tag_active_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= any_now;
  end

  assign drain_o = any_q & ~any_now;
  assign led_o   = led_en_i & atapi_i & any_now;
endmodule

// File: rtl/lpc_req_ctrl.sv
module lpc_req_ctrl
  import lpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] wcmd_i,
  input  logic             link_idle_i,
  input  logic             drain_i,
  input  logic             auto_en_i,
  input  logic             sel_slumber_i,
  input  logic             ack_i,
  input  logic             nak_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             req_o,
  output logic [PWR_W-1:0] tgt_o,
  output logic [PWR_W-1:0] pwr_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             req_q, req_d;
  logic [PWR_W-1:0] tgt_q, tgt_d;
  logic [PWR_W-1:0] pwr_q, pwr_d;
  logic             busy;
  logic             take_wr;
  logic             act;
  cmd_dec_t         dec;

  assign busy    = (cmd_q != CMD_NOP) | req_q;
  assign take_wr = we_i & link_idle_i & ~busy;
  assign dec     = decode_cmd(cmd_q);
  // a valid command needs a move; low->low is refused
  assign act     = dec.valid & (dec.tgt != pwr_q) &
                   ((pwr_q == PWR_ACTIVE) | (dec.tgt == PWR_ACTIVE));

  always_comb begin
    cmd_d = cmd_q;
    req_d = req_q;
    tgt_d = tgt_q;
    pwr_d = pwr_q;
    if (req_q) begin
      if (ack_i) begin
        pwr_d = tgt_q;
        req_d = 1'b0;
        cmd_d = CMD_NOP;
      end else if (nak_i) begin
        req_d = 1'b0;
        cmd_d = CMD_NOP;
      end
    end else if (cmd_q != CMD_NOP) begin
      if (act) begin
        req_d = 1'b1;
        tgt_d = dec.tgt;
      end else begin
        cmd_d = CMD_NOP;
      end
    end else begin
      if (take_wr) cmd_d = wcmd_i;
      if (drain_i && auto_en_i && (pwr_q == PWR_ACTIVE) &&
          !(take_wr && (wcmd_i != CMD_NOP))) begin
        req_d = 1'b1;
        tgt_d = sel_slumber_i ? PWR_SLUMBER : PWR_PARTIAL;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP;
      req_q <= 1'b0;
      tgt_q <= PWR_ACTIVE;
      pwr_q <= PWR_ACTIVE;
    end else begin
      cmd_q <= cmd_d;
      req_q <= req_d;
      tgt_q <= tgt_d;
      pwr_q <= pwr_d;
    end
  end

  assign cmd_o = cmd_q;
  assign req_o = req_q;
  assign tgt_o = tgt_q;
  assign pwr_o = pwr_q;
endmodule

// File: rtl/link_pwr_cmd_ctrl.sv
module link_pwr_cmd_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned SLOTS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              link_idle_i,
  input  logic [SLOTS-1:0]  cmd_issue_i,
  input  logic [SLOTS-1:0]  tag_active_i,
  output logic              lnk_req_o,
  output logic [PWR_W-1:0]  lnk_tgt_o,
  input  logic              lnk_ack_i,
  input  logic              lnk_nak_i,
  output logic [PWR_W-1:0]  pwr_state_o,
  output logic              led_o
);
  logic              sel_slumber, auto_en, led_en, atapi;
  logic [ONCE_W-1:0] once_cfg;
  logic              drain;
  logic [CMD_W-1:0]  cmd;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[23:22], reg_wdata_i[PWR_HI:0]};

  lpc_cfg_regs u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .cfg_wdata_i   (reg_wdata_i[SEL_BIT:ATAPI_BIT]),
    .once_wdata_i  (reg_wdata_i[ONCE_HI:ONCE_LO]),
    .sel_slumber_o (sel_slumber),
    .auto_en_o     (auto_en),
    .led_en_o      (led_en),
    .atapi_o       (atapi),
    .once_o        (once_cfg)
  );

  lpc_drain_det #(.SLOTS(SLOTS)) u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_issue_i  (cmd_issue_i),
    .tag_active_i (tag_active_i),
    .led_en_i     (led_en),
    .atapi_i      (atapi),
    .drain_o      (drain),
    .led_o        (led_o)
  );

  lpc_req_ctrl u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .wcmd_i        (reg_wdata_i[CMD_HI:CMD_LO]),
    .link_idle_i   (link_idle_i),
    .drain_i       (drain),
    .auto_en_i     (auto_en),
    .sel_slumber_i (sel_slumber),
    .ack_i         (lnk_ack_i),
    .nak_i         (lnk_nak_i),
    .cmd_o         (cmd),
    .req_o         (lnk_req_o),
    .tgt_o         (lnk_tgt_o),
    .pwr_o         (pwr_state_o)
  );

  always_comb begin
    reg_rdata_o                   = '0;
    reg_rdata_o[CMD_HI:CMD_LO]    = cmd;
    reg_rdata_o[SEL_BIT]          = sel_slumber;
    reg_rdata_o[AUTO_BIT]         = auto_en;
    reg_rdata_o[LEDEN_BIT]        = led_en;
    reg_rdata_o[ATAPI_BIT]        = atapi;
    reg_rdata_o[ONCE_HI:ONCE_LO]  = once_cfg;
    reg_rdata_o[PWR_HI:PWR_LO]    = pwr_state_o;
  end
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int unsigned SLOTS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [31:0]       reg_rdata_o,
  input logic              link_idle_i,
  input logic              lnk_req_o,
  input logic [1:0]        lnk_tgt_o,
  input logic              lnk_ack_i,
  input logic              lnk_nak_i,
  input logic [1:0]        pwr_state_o,
  input logic              led_o
);
  logic wr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_seen_q <= 1'b0;
    else if (reg_we_i) wr_seen_q <= 1'b1;
  end

  p_ignore_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_idle_i && reg_we_i && reg_rdata_o[31:28] == 4'h0 && !lnk_req_o)
    |=> reg_rdata_o[31:28] == 4'h0);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_req_o && !lnk_ack_i && !lnk_nak_i) |=> (lnk_req_o && $stable(lnk_tgt_o)));

  p_cmd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lnk_req_o) |-> reg_rdata_o[31:28] == 4'h0);

  p_nak_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_req_o && lnk_nak_i && !lnk_ack_i) |=> $stable(pwr_state_o));

  p_low_to_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_req_o && pwr_state_o != 2'd0) |-> lnk_tgt_o == 2'd0);

  p_led_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> (reg_rdata_o[25] && reg_rdata_o[24]));

  p_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_seen_q && reg_we_i) |=> $stable(reg_rdata_o[21:18]));

  p_rsvd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[23:22] == 2'b00 && reg_rdata_o[15:0] == 16'h0));
endmodule

bind link_pwr_cmd_ctrl lpc_checker #(.SLOTS(SLOTS)) u_lpc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .link_idle_i (link_idle_i),
  .lnk_req_o   (lnk_req_o),
  .lnk_tgt_o   (lnk_tgt_o),
  .lnk_ack_i   (lnk_ack_i),
  .lnk_nak_i   (lnk_nak_i),
  .pwr_state_o (pwr_state_o),
  .led_o       (led_o)
);

// File: tb/link_pwr_cmd_ctrl_bench.sv
module link_pwr_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;
  localparam int WDOG_CYCLES = 20000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [31:0]      reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  logic             link_idle_i = 1'b1;
  logic [SLOTS-1:0] cmd_issue_i = '0;
  logic [SLOTS-1:0] tag_active_i = '0;
  logic             lnk_req_o;
  logic [1:0]       lnk_tgt_o;
  logic             lnk_ack_i = 1'b0;
  logic             lnk_nak_i = 1'b0;
  logic [1:0]       pwr_state_o;
  logic             led_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // responder config
  bit reject_low = 0;
  int resp_delay = 1;
  int resp_cnt = 0;

  // reference model state
  int m_cmd = 0, m_tgt = 0, m_pwr = 0, m_once = 0, m_cfg = 0;
  bit m_req = 0, m_once_done = 0, m_pend = 0;

  bit [3:0] cfg_bits = 4'h0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_pwr_cmd_ctrl #(.SLOTS(SLOTS)) u_link_pwr_cmd_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .link_idle_i,
    .cmd_issue_i, .tag_active_i, .lnk_req_o, .lnk_tgt_o, .lnk_ack_i,
    .lnk_nak_i, .pwr_state_o, .led_o
  );

  function automatic int tgt_of(int c);
    if (c == 1) return 0;
    if (c == 2) return 1;
    if (c == 6) return 2;
    return -1;
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmd = 0; m_tgt = 0; m_pwr = 0; m_once = 0; m_cfg = 0;
      m_req = 0; m_once_done = 0; m_pend = 0;
    end else begin
      int n_cmd, n_tgt, n_pwr, t;
      bit n_req, busy, took, pend_now;
      n_cmd = m_cmd; n_tgt = m_tgt; n_pwr = m_pwr; n_req = m_req;
      busy = (m_cmd != 0) || m_req;
      took = reg_we_i && link_idle_i && !busy;
      pend_now = (cmd_issue_i != 0) || (tag_active_i != 0);
      if (m_req) begin
        if (lnk_ack_i) begin n_pwr = m_tgt; n_req = 0; n_cmd = 0; end
        else if (lnk_nak_i) begin n_req = 0; n_cmd = 0; end
      end else if (m_cmd != 0) begin
        t = tgt_of(m_cmd);
        if (t >= 0 && t != m_pwr && (m_pwr == 0 || t == 0)) begin
          n_req = 1; n_tgt = t;
        end else n_cmd = 0;
      end else begin
        if (took) n_cmd = int'(reg_wdata_i[31:28]);
        if (m_pend && !pend_now && m_cfg[2] && m_pwr == 0 &&
            !(took && reg_wdata_i[31:28] != 0)) begin
          n_req = 1; n_tgt = m_cfg[3] ? 2 : 1;
        end
      end
      if (reg_we_i) begin
        m_cfg = int'(reg_wdata_i[27:24]);
        if (!m_once_done) begin m_once = int'(reg_wdata_i[21:18]); m_once_done = 1; end
      end
      m_pend = pend_now;
      m_cmd = n_cmd; m_tgt = n_tgt; m_pwr = n_pwr; m_req = n_req;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit [31:0] exp_rd;
      bit exp_led;
      exp_rd = {m_cmd[3:0], m_cfg[3:0], 2'b00, m_once[3:0], m_pwr[1:0], 16'h0};
      exp_led = m_cfg[1] && m_cfg[0] && ((cmd_issue_i != 0) || (tag_active_i != 0));
      check("R2/R4/R6 cmd field", int'(reg_rdata_o[31:28]), int'(exp_rd[31:28]));
      check("R11 read word", int'(reg_rdata_o), int'(exp_rd));
      check("R3 req", int'(lnk_req_o), int'(m_req));
      if (m_req) check("R3 target", int'(lnk_tgt_o), m_tgt);
      check("R5 power state", int'(pwr_state_o), m_pwr);
      check("R9 led", int'(led_o), int'(exp_led));
    end
  end

  // device responder
  always @(negedge clk_i) begin
    #2;
    lnk_ack_i = 1'b0;
    lnk_nak_i = 1'b0;
    if (!lnk_req_o) resp_cnt = 0;
    else begin
      resp_cnt++;
      if (resp_cnt == resp_delay) begin
        if (reject_low && lnk_tgt_o != 2'd0) lnk_nak_i = 1'b1;
        else lnk_ack_i = 1'b1;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(bit [3:0] cmd, bit [3:0] once);
    @(negedge clk_i); #1;
    reg_wdata_i = {cmd, cfg_bits, 2'b00, once, 18'h0};
    reg_we_i = 1'b1;
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
    reg_wdata_i = '0;
  endtask

  task automatic settle();
    int n = 0;
    while ((lnk_req_o || reg_rdata_o[31:28] != 0) && n < 50) begin
      @(negedge clk_i); n++;
    end
    cyc(2);
  endtask

  initial begin
    fork
      begin
        while (cycles < WDOG_CYCLES && !done) begin @(posedge clk_i); cycles++; end
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          done = 1;
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    cyc(3);
    check("R1 reset word", int'(reg_rdata_o), 0);
    check("R1 reset req", int'(lnk_req_o), 0);
    check("R1 reset pwr", int'(pwr_state_o), 0);
    #1 rst_ni = 1'b1;
    cyc(2);

    // R10 first write sets the once nibble, later ones are ignored
    wr(4'h0, 4'hA); cyc(1);
    check("R10 once first", int'(reg_rdata_o[21:18]), 'hA);
    wr(4'h0, 4'h5); cyc(1);
    check("R10 once locked", int'(reg_rdata_o[21:18]), 'hA);

    // R2 link not idle: write ignored
    link_idle_i = 1'b0;
    wr(4'h2, 4'h0); cyc(1);
    check("R2 non-idle cmd", int'(reg_rdata_o[31:28]), 0);
    check("R2 non-idle req", int'(lnk_req_o), 0);
    link_idle_i = 1'b1;

    // R3 partial accepted
    wr(4'h2, 4'h0); settle();
    check("R3 to partial", int'(pwr_state_o), 1);
    check("R4 cleared", int'(reg_rdata_o[31:28]), 0);

    // R7 partial -> slumber refused
    wr(4'h6, 4'h0); settle();
    check("R7 stays partial", int'(pwr_state_o), 1);
    // R6 same state and reserved
    wr(4'h2, 4'h0); settle();
    check("R6 same state", int'(pwr_state_o), 1);
    wr(4'h4, 4'h0); settle();
    check("R6 reserved", int'(pwr_state_o), 1);
    wr(4'hF, 4'h0); settle();
    check("R6 reserved F", int'(reg_rdata_o[31:28]), 0);

    // back to active
    wr(4'h1, 4'h0); settle();
    check("R3 to active", int'(pwr_state_o), 0);

    // R5 rejected slumber
    reject_low = 1;
    wr(4'h6, 4'h0); settle();
    check("R5 rejected", int'(pwr_state_o), 0);
    reject_low = 0;

    // R2 write while request open
    resp_delay = 4;
    wr(4'h2, 4'h0);
    wr(4'h1, 4'h0);
    settle();
    check("R2 busy ignored", int'(pwr_state_o), 1);
    resp_delay = 1;
    wr(4'h1, 4'h0); settle();
    check("R3 active again", int'(pwr_state_o), 0);

    // R8 automatic slumber
    cfg_bits = 4'b1100;
    wr(4'h0, 4'h0);
    @(negedge clk_i); #1 cmd_issue_i = 32'h1; tag_active_i = 32'h80;
    cyc(3);
    #1 cmd_issue_i = '0;
    cyc(2);
    #1 tag_active_i = '0;
    settle();
    check("R8 auto slumber", int'(pwr_state_o), 2);
    wr(4'h1, 4'h0); settle();
    cfg_bits = 4'b0100;
    wr(4'h0, 4'h0);
    @(negedge clk_i); #1 tag_active_i = 32'h4;
    cyc(2);
    #1 tag_active_i = '0;
    settle();
    check("R8 auto partial", int'(pwr_state_o), 1);
    wr(4'h1, 4'h0); settle();

    // R9 LED gating
    cfg_bits = 4'b0001;
    wr(4'h0, 4'h0);
    @(negedge clk_i); #1 tag_active_i = 32'h10;
    cyc(1);
    check("R9 led off w/o enable", int'(led_o), 0);
    cfg_bits = 4'b0011;
    wr(4'h0, 4'h0); cyc(1);
    check("R9 led on", int'(led_o), 1);
    #1 tag_active_i = '0; cmd_issue_i = 32'h2;
    cyc(1);
    check("R9 led on issue", int'(led_o), 1);
    #1 cmd_issue_i = '0;
    cyc(2);
    check("R9 led off idle", int'(led_o), 0);

    cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule